// File: doc/BRIEF.md
# Sign-Magnitude Significand Adder with Sign Resolution

This block is the arithmetic stage of a single-precision floating-point add/subtract datapath. It takes two significands that the alignment stage has already brought to a common exponent. Each significand is 27 bits wide: the hidden integer bit, 23 fraction bits, and then guard, round and sticky bits. The block also takes the sign of each operand and a control that asks for subtraction. From the two signs and the control it decides whether the magnitudes must be added or subtracted.

The block works out the sign of the result in a sign-resolution unit of its own. The magnitude arithmetic uses a structural ripple-carry chain built with a generate loop. For an effective subtraction the smaller magnitude is always taken from the larger one, so the magnitude handed on is never negative. When the second operand is the larger one, the result sign flips. An exact zero from a subtraction is given a positive sign, as round-to-nearest requires. For an effective addition, the carry out of the top bit is passed on as an overflow flag for the normaliser. All results are registered once.

Top module: `sadd_core`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released with no edge taken since, sum_o, carry_o, sign_o and eff_sub_o are all 0.
- R2: The result appears on the outputs after exactly one rising clock edge. Before that edge the outputs keep showing the previous result.
- R3: eff_sub_o equals sign_a_i XOR sign_b_i XOR op_sub_i. Here op_sub_i = 1 requests A minus B, and a sign bit of 1 means negative.
- R4: On effective addition, {carry_o, sum_o} is the 28-bit sum sig_a_i + sig_b_i, and sign_o equals sign_a_i.
- R5: On effective subtraction with sig_a_i >= sig_b_i, sum_o = sig_a_i - sig_b_i, carry_o = 0, and sign_o = sign_a_i unless the difference is zero.
- R6: On effective subtraction with sig_b_i > sig_a_i, the operands are swapped so that sum_o = sig_b_i - sig_a_i, carry_o = 0, and sign_o is the inverse of sign_a_i.
- R7: On effective subtraction of equal magnitudes, sum_o = 0 and sign_o = 0, whatever the input signs.
- R8: The guard, round and sticky bits (bits 2..0 of each significand) take full part in the subtraction, so a borrow out of them propagates into the fraction bits. For example, 8 - 1 gives 7.
- R9: carry_o is 1 exactly when an effective addition overflows bit 26. It is never 1 on an effective subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sub_i | input | 1 | 1 requests A minus B, 0 requests A plus B |
| sign_a_i | input | 1 | Sign of operand A (1 = negative) |
| sign_b_i | input | 1 | Sign of operand B (1 = negative) |
| sig_a_i | input | 27 | Aligned significand A: hidden bit, fraction, guard, round, sticky |
| sig_b_i | input | 27 | Aligned significand B, same layout |
| sum_o | output | 27 | Non-negative magnitude result |
| carry_o | output | 1 | Carry out of an effective addition |
| sign_o | output | 1 | Resolved sign of the result |
| eff_sub_o | output | 1 | 1 when the magnitudes were subtracted |

## Verification
The hardest case to reach is a subtraction whose difference is exactly zero or just one unit. In those cases the swap decision, the zero-sign rule and the borrow through the sticky bit all depend on the two magnitudes being almost equal. Uniform random 27-bit operands almost never produce such pairs. The stimulus therefore builds B from A: some B values are copies of A, some are A with one low bit toggled, and some are A shifted right by a random amount. Every sign combination is crossed with the subtract control. Directed vectors add the 8 - 1 borrow chain and a full-scale carry-out.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    localparam int unsigned SADD_FRAC_W = 23;
    localparam int unsigned SADD_XTRA_W = 3;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } eff_op_e;

endpackage

// File: rtl/sadd_ripple.sv
module sadd_ripple #(
    parameter int unsigned W = 27
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic half;
        assign half         = a_i[i] ^ b_i[i];
        assign sum_o[i]     = half ^ chain[i];
        assign chain[i+1]   = (a_i[i] & b_i[i]) | (chain[i] & half);
    end

    assign cout_o = chain[W];

endmodule

// File: rtl/sadd_sign_res.sv
module sadd_sign_res
    import sadd_pkg::*;
(
    input  logic    sign_a_i,
    input  logic    sign_b_i,
    input  logic    op_sub_i,
    input  logic    a_ge_b_i,
    input  logic    b_ge_a_i,
    output eff_op_e op_kind_o,
    output logic    swap_o,
    output logic    sign_o
);

    logic is_sub;
    logic is_tie;

    assign is_sub    = sign_a_i ^ sign_b_i ^ op_sub_i;
    assign op_kind_o = is_sub ? OP_SUB : OP_ADD;
    assign is_tie    = a_ge_b_i & b_ge_a_i;
    assign swap_o    = is_sub & ~a_ge_b_i;

    assign sign_o = !is_sub ? sign_a_i :
                    is_tie  ? 1'b0     :
                    swap_o  ? ~sign_a_i : sign_a_i;

endmodule

// File: rtl/sadd_core.sv
module sadd_core
    import sadd_pkg::*;
#(
    parameter int unsigned FRAC_W = SADD_FRAC_W,
    parameter int unsigned XTRA_W = SADD_XTRA_W,
    localparam int unsigned SIG_W = 1 + FRAC_W + XTRA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_sub_i,
    input  logic             sign_a_i,
    input  logic             sign_b_i,
    input  logic [SIG_W-1:0] sig_a_i,
    input  logic [SIG_W-1:0] sig_b_i,
    output logic [SIG_W-1:0] sum_o,
    output logic             carry_o,
    output logic             sign_o,
    output logic             eff_sub_o
);

    typedef struct packed {
        logic [SIG_W-1:0] mag;
        logic             carry;
        logic             sign;
        logic             sub;
    } res_t;

    res_t res_d, res_q;

    eff_op_e          op_kind;
    logic             eff_sub;
    logic             swap;
    logic             sign_res;
    logic [SIG_W-1:0] b_path;
    logic [SIG_W-1:0] sum_ab, sum_ba;
    logic             cout_ab, cout_ba;

    assign eff_sub = (op_kind == OP_SUB);
    assign b_path  = eff_sub ? ~sig_b_i : sig_b_i;

    sadd_ripple #(.W(SIG_W)) u_add_ab (
        .a_i    (sig_a_i),
        .b_i    (b_path),
        .cin_i  (eff_sub),
        .sum_o  (sum_ab),
        .cout_o (cout_ab)
    );

    sadd_ripple #(.W(SIG_W)) u_sub_ba (
        .a_i    (sig_b_i),
        .b_i    (~sig_a_i),
        .cin_i  (1'b1),
        .sum_o  (sum_ba),
        .cout_o (cout_ba)
    );

    sadd_sign_res u_sign (
        .sign_a_i  (sign_a_i),
        .sign_b_i  (sign_b_i),
        .op_sub_i  (op_sub_i),
        .a_ge_b_i  (cout_ab),
        .b_ge_a_i  (cout_ba),
        .op_kind_o (op_kind),
        .swap_o    (swap),
        .sign_o    (sign_res)
    );

    always_comb begin
        res_d       = res_q;
        res_d.sub   = eff_sub;
        res_d.sign  = sign_res;
        res_d.mag   = swap ? sum_ba : sum_ab;
        res_d.carry = eff_sub ? 1'b0 : cout_ab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign sum_o     = res_q.mag;
    assign carry_o   = res_q.carry;
    assign sign_o    = res_q.sign;
    assign eff_sub_o = res_q.sub;

endmodule

// File: rtl/sadd_core_chk.sv
module sadd_core_chk #(
    parameter int unsigned SIG_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_sub_i,
    input logic             sign_a_i,
    input logic             sign_b_i,
    input logic [SIG_W-1:0] sig_a_i,
    input logic [SIG_W-1:0] sig_b_i,
    input logic [SIG_W-1:0] sum_o,
    input logic             carry_o,
    input logic             sign_o,
    input logic             eff_sub_o
);

    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (sum_o == '0 && !carry_o && !sign_o && !eff_sub_o); // R1
        end
    end

    AST_EFF_OP: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> eff_sub_o == ($past(sign_a_i) ^ $past(sign_b_i) ^ $past(op_sub_i))); // R3

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !eff_sub_o) |->
            ({carry_o, sum_o} == ({1'b0, $past(sig_a_i)} + {1'b0, $past(sig_b_i)}))); // R4

    AST_ADD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !eff_sub_o) |-> sign_o == $past(sign_a_i)); // R4

    AST_SUB_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        eff_sub_o |-> !carry_o); // R9

    AST_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sub_o && sum_o == '0) |-> !sign_o); // R7

    AST_SUB_GE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && eff_sub_o && $past(sig_a_i) >= $past(sig_b_i)) |->
            sum_o == $past(sig_a_i) - $past(sig_b_i)); // R5

    AST_SUB_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && eff_sub_o && $past(sig_b_i) > $past(sig_a_i)) |->
            (sum_o == $past(sig_b_i) - $past(sig_a_i) && sign_o == !$past(sign_a_i))); // R6

endmodule

bind sadd_core sadd_core_chk #(.SIG_W(SIG_W)) u_chk (.*);

// File: tb/sadd_core_bench.sv
module sadd_core_bench;

    localparam int W = 27;
    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_sub = 1'b0;
    logic         sa = 1'b0;
    logic         sb = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] sum;
    logic         carry, sgn, esub;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sadd_core u_sadd_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sub_i  (op_sub),
        .sign_a_i  (sa),
        .sign_b_i  (sb),
        .sig_a_i   (a),
        .sig_b_i   (b),
        .sum_o     (sum),
        .carry_o   (carry),
        .sign_o    (sgn),
        .eff_sub_o (esub)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic o, input logic s_a, input logic s_b,
                                  input logic [W-1:0] x, input logic [W-1:0] y,
                                  output logic [W-1:0] m, output logic c,
                                  output logic s, output logic e, output string tag);
        logic [W:0] wide;
        e = s_a ^ s_b ^ o;
        if (!e) begin
            wide = {1'b0, x} + {1'b0, y};
            m = wide[W-1:0];
            c = wide[W];
            s = s_a;
            tag = c ? "R9" : "R4";
        end else if (x >= y) begin
            m = x - y;
            c = 1'b0;
            s = (m == '0) ? 1'b0 : s_a;
            tag = (m == '0) ? "R7" : "R5";
        end else begin
            m = y - x;
            c = 1'b0;
            s = ~s_a;
            tag = "R6";
        end
    endfunction

    task automatic apply(input logic o, input logic s_a, input logic s_b,
                         input logic [W-1:0] x, input logic [W-1:0] y, input string extra);
        logic [W-1:0] m;
        logic c, s, e;
        string tag;
        @(negedge clk);
        op_sub = o; sa = s_a; sb = s_b; a = x; b = y;
        model(o, s_a, s_b, x, y, m, c, s, e, tag);
        @(negedge clk);
        check({"R3 eff_sub", extra}, 64'(esub), 64'(e));
        check({tag, " magnitude", extra}, 64'(sum), 64'(m));
        check({tag, " carry", extra}, 64'(carry), 64'(c));
        check({tag, " sign", extra}, 64'(sgn), 64'(s));
    endtask

    initial begin
        logic [W-1:0] prev_sum;
        void'($urandom(32'd1234));
        #3;
        check("R1 reset sum", 64'(sum), 64'd0);
        check("R1 reset flags", 64'({carry, sgn, esub}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", 64'({sum, carry, sgn, esub}), 64'd0);

        // R2: hold before edge, update after
        apply(1'b0, 1'b0, 1'b0, 27'd5, 27'd3, " R2 first");
        prev_sum = sum;
        @(negedge clk);
        a = 27'd100; b = 27'd1; op_sub = 1'b0; sa = 1'b0; sb = 1'b0;
        #1;
        check("R2 hold before edge", 64'(sum), 64'(prev_sum));
        @(negedge clk);
        check("R2 after one edge", 64'(sum), 64'd101);

        // R8: borrow through guard/round/sticky
        apply(1'b1, 1'b0, 1'b0, 27'd8, 27'd1, " R8 borrow");
        apply(1'b0, 1'b0, 1'b1, 27'h4000000, 27'h0000001, " R8 sticky");
        // R7 zero sign for every sign pattern
        apply(1'b1, 1'b1, 1'b1, 27'h4abcdef, 27'h4abcdef, " R7 neg-neg");
        apply(1'b0, 1'b1, 1'b0, 27'h5555555, 27'h5555555, " R7 mixed");
        // R9 full-scale carry, R4 signed add
        apply(1'b0, 1'b1, 1'b1, 27'h7ffffff, 27'h7ffffff, " R9 max");
        apply(1'b1, 1'b1, 1'b0, 27'h4000000, 27'h4000000, " R9 carry");
        // R6 swap with unit difference
        apply(1'b1, 1'b0, 1'b0, 27'h4000000, 27'h4000001, " R6 unit");
        apply(1'b0, 1'b1, 1'b0, 27'd0, 27'h7ffffff, " R6 zero-a");

        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] x, y;
            logic [2:0] sel;
            x = W'($urandom);
            if ($urandom % 2 == 0) x[W-1] = 1'b1;
            sel = 3'($urandom % 5);
            case (sel)
                3'd0: y = x;
                3'd1: y = x ^ (W'(1) << ($urandom % 4));
                3'd2: y = x >> ($urandom % W);
                3'd3: y = W'($urandom);
                default: y = x + W'($urandom % 3) - W'(1);
            endcase
            if ($urandom % 2 == 0) begin
                logic [W-1:0] t;
                t = x; x = y; y = t;
            end
            apply(1'($urandom), 1'($urandom), 1'($urandom), x, y, " random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule